// File: doc/BRIEF.md
# Serial Command Receiver with Fault Flag and Chip-Select Gap Guard

This block is the serial front end of an output driver. It sits in the system clock domain and works from the raw serial pins: a serial clock, an active-low chip select and a data input. Each pin passes through a two-flop synchronizer, and the block detects pin edges in the system clock domain, so the system clock must run at least four times faster than the serial clock. While the chip is selected, the master shifts a 24-bit command in on the data input, most significant bit first. At the same time the block shifts out a status word. That status word is captured when chip select falls, and its top bit is the global fault flag, so the fault flag is on the output before the first serial clock edge. The data output is enabled only while chip select is low.

A received command reaches the control register only when chip select is released, and only if exactly 24 serial clock rising edges were seen. A frame of any other length is dropped and raises a sticky frame error. A mode tracker starts in standby after reset and enters active mode when a command is accepted. The block enforces a minimum chip-select-high gap: a longer gap after the frame that woke the block from standby, and a shorter one in active mode. A frame that begins too early is ignored and raises a sticky gap error.

Top module: `spi_cmd_slave`

## Requirements
- R1: The command is 24 bits, most significant bit first. The data input is taken at each synchronized serial clock rising edge while chip select is low.
- R2: The outgoing word is {fault_i, status_i[22:0]}, both captured at the chip-select falling event, and it is sent MSB first. do_o moves to the next bit only after a synchronized serial clock falling edge.
- R3: do_oe_o is low while chip select is high. It goes high on the chip-select falling event and low on the rising event, and do_o is 0 whenever do_oe_o is low.
- R4: After chip select falls, do_o shows the captured fault_i value before any serial clock edge.
- R5: ctrl_o takes the received word only on a chip-select rising event that closes a frame of exactly 24 rising edges whose gap check passed. At all other times ctrl_o holds its value.
- R6: A frame whose count of rising edges is not 24 leaves ctrl_o unchanged and sets frame_err_o, which stays set until reset.
- R7: The gap is measured in system cycles from one chip-select rising event to the next falling event. It must be at least STBY_US×SYS_MHZ cycles after the frame that woke the block from standby, and ACT_US×SYS_MHZ cycles otherwise. A shorter gap sets gap_err_o, which stays set until reset, and the frame is not committed.
- R8: active_o rises when a frame is committed. A high stby_req_i makes active_o low at the next edge and returns the tracker to standby.
- R9: Reset sets ctrl_o to zero, makes do_oe_o low, clears both error flags, puts the tracker in standby and treats the gap as already met.
- R10: Every pin change takes effect in the outputs at the third system clock rising edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock pin, idle low |
| csn_i | input | 1 | Chip select pin, active low |
| di_i | input | 1 | Serial data input pin |
| fault_i | input | 1 | Global fault flag, system domain |
| status_i | input | 23 | Status bits sent below the fault flag |
| stby_req_i | input | 1 | Returns the mode tracker to standby |
| do_o | output | 1 | Serial data output value |
| do_oe_o | output | 1 | Output enable for the data pin (low means high impedance) |
| ctrl_o | output | 24 | Output control register |
| frame_err_o | output | 1 | Sticky wrong-length frame flag |
| gap_err_o | output | 1 | Sticky chip-select gap violation flag |
| active_o | output | 1 | Mode tracker is in active mode |

## Verification
Every pin change counts as seen at a system clock edge k, and its results show in the outputs after edge k+2. Those results are enable and status shifting on do_o, the commit to ctrl_o, the error flags and the mode flag. The bench drives the pins on falling system clock edges. It keeps a behavioural model that delays the pins by the same three stages, and it compares every output with the model on every falling edge. The directed checks wait at least four system cycles after the last pin change before they sample, so the commit or flag they look for has already been registered. Gap lengths are counted in system cycles from the driven chip-select edges, and both rising and falling events carry the same delay, so the gap counts as the bench wrote it.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic {MODE_STBY = 1'b0, MODE_ACT = 1'b1} mode_e;

  function automatic int us_to_cyc(input int mhz, input int us);
    return mhz * us;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int           N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
        prev_q <= RST_VAL[g];
      end else begin
        meta_q <= pin_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign lvl_o[g]  = sync_q;
    assign rise_o[g] = sync_q & ~prev_q;
    assign fall_o[g] = ~sync_q & prev_q;
  end
endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift #(
  parameter int FRAME_W = 24,
  parameter int CW      = $clog2(FRAME_W + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csn_fall_i,
  input  logic               csn_rise_i,
  input  logic               sel_i,
  input  logic               sck_rise_i,
  input  logic               sck_fall_i,
  input  logic               di_i,
  input  logic [FRAME_W-1:0] load_i,
  output logic [FRAME_W-1:0] rx_o,
  output logic [CW-1:0]      cnt_o,
  output logic               tx_bit_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(FRAME_W + 1);

  logic [FRAME_W-1:0] rx_q, tx_q;
  logic [CW-1:0]      cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= '0;
      tx_q  <= '0;
      cnt_q <= '0;
    end else if (csn_fall_i) begin
      tx_q  <= load_i;
      cnt_q <= '0;
    end else if (!csn_rise_i && sel_i) begin
      if (sck_rise_i) begin
        rx_q <= {rx_q[FRAME_W-2:0], di_i};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (sck_fall_i) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign rx_o     = rx_q;
  assign cnt_o    = cnt_q;
  assign tx_bit_o = tx_q[FRAME_W-1];

  // R2: the outgoing bit moves only on a serial clock fall or a new load
  p_tx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_fall_i && !csn_fall_i) |=> $stable(tx_q));
  // R6: the edge count saturates one past the frame length
  p_cnt_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || $past(csn_fall_i)));
endmodule

// File: rtl/spi_gap_guard.sv
module spi_gap_guard
  import spi_cmd_pkg::*;
#(
  parameter int SYS_MHZ = 100,
  parameter int STBY_US = 20,
  parameter int ACT_US  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csn_fall_i,
  input  logic csn_rise_i,
  input  logic csn_high_i,
  input  logic commit_i,
  input  logic stby_req_i,
  output logic win_ok_o,
  output logic gap_err_o,
  output logic active_o
);
  localparam int LONG_CYC  = us_to_cyc(SYS_MHZ, STBY_US);
  localparam int SHORT_CYC = us_to_cyc(SYS_MHZ, ACT_US);
  localparam int GW        = $clog2(LONG_CYC + 1);

  mode_e         mode_q;
  logic          long_q, win_q, err_q;
  logic [GW-1:0] gap_q, need;
  logic          met;

  assign need = long_q ? GW'(LONG_CYC) : GW'(SHORT_CYC);
  assign met  = gap_q >= need;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= GW'(LONG_CYC);
    end else if (csn_rise_i) begin
      gap_q <= GW'(1);
    end else if (csn_high_i && gap_q != GW'(LONG_CYC)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= 1'b0;
      err_q <= 1'b0;
    end else if (csn_fall_i) begin
      win_q <= met;
      if (!met) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STBY;
      long_q <= 1'b1;
    end else begin
      if (commit_i) begin
        mode_q <= MODE_ACT;
        long_q <= (mode_q == MODE_STBY);
      end
      if (stby_req_i) mode_q <= MODE_STBY;
    end
  end

  assign win_ok_o  = win_q;
  assign gap_err_o = err_q;
  assign active_o  = (mode_q == MODE_ACT);

  p_gap_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_stby_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_req_i |=> !active_o);
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int FRAME_W = 24,
  parameter int SYS_MHZ = 100,
  parameter int STBY_US = 20,
  parameter int ACT_US  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               csn_i,
  input  logic               di_i,
  input  logic               fault_i,
  input  logic [FRAME_W-2:0] status_i,
  input  logic               stby_req_i,
  output logic               do_o,
  output logic               do_oe_o,
  output logic [FRAME_W-1:0] ctrl_o,
  output logic               frame_err_o,
  output logic               gap_err_o,
  output logic               active_o
);
  localparam int CW = $clog2(FRAME_W + 2);
  // pin order {di, csn, sck}; csn idles high
  localparam logic [2:0] PIN_RST = 3'b010;

  logic [2:0]         lvl, rise, fall;
  logic               csn_fall, csn_rise, sel, sck_rise, sck_fall;
  logic [FRAME_W-1:0] rx_word;
  logic [CW-1:0]      edge_cnt;
  logic               tx_bit, win_ok, full, commit;
  logic [FRAME_W-1:0] ctrl_q;
  logic               oe_q, ferr_q;

  spi_pin_sync #(.N(3), .RST_VAL(PIN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i ({di_i, csn_i, sck_i}),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign csn_fall = fall[1];
  assign csn_rise = rise[1];
  assign sel      = ~lvl[1];
  assign sck_rise = rise[0];
  assign sck_fall = fall[0];

  spi_frame_shift #(.FRAME_W(FRAME_W), .CW(CW)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .csn_fall_i(csn_fall),
    .csn_rise_i(csn_rise),
    .sel_i     (sel),
    .sck_rise_i(sck_rise),
    .sck_fall_i(sck_fall),
    .di_i      (lvl[2]),
    .load_i    ({fault_i, status_i}),
    .rx_o      (rx_word),
    .cnt_o     (edge_cnt),
    .tx_bit_o  (tx_bit)
  );

  assign full   = (edge_cnt == CW'(FRAME_W));
  assign commit = csn_rise & full & win_ok;

  spi_gap_guard #(.SYS_MHZ(SYS_MHZ), .STBY_US(STBY_US), .ACT_US(ACT_US)) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .csn_fall_i(csn_fall),
    .csn_rise_i(csn_rise),
    .csn_high_i(lvl[1]),
    .commit_i  (commit),
    .stby_req_i(stby_req_i),
    .win_ok_o  (win_ok),
    .gap_err_o (gap_err_o),
    .active_o  (active_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      oe_q   <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (csn_fall) oe_q <= 1'b1;
      if (csn_rise) begin
        oe_q <= 1'b0;
        if (!full) ferr_q <= 1'b1;
      end
      if (commit) ctrl_q <= rx_word;
    end
  end

  assign do_o        = oe_q & tx_bit;
  assign do_oe_o     = oe_q;
  assign ctrl_o      = ctrl_q;
  assign frame_err_o = ferr_q;

  p_ctrl_on_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csn_rise |=> $stable(ctrl_o));
  p_oe_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_rise |=> !do_oe_o);
  p_fault_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_fall |=> (do_oe_o && do_o == $past(fault_i)));
  p_ferr_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> frame_err_o);
endmodule

// File: tb/sim_spi_cmd_slave.sv
module sim_spi_cmd_slave;
  localparam int W = 24;
  localparam int LONG_N = 2000;
  localparam int SHORT_N = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, di = 1'b0, fault = 1'b0, stby = 1'b0;
  logic [W-2:0] status = '0;
  logic do_v, oe, ferr, gerr, act;
  logic [W-1:0] ctrl;
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  spi_cmd_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .di_i(di),
    .fault_i(fault), .status_i(status), .stby_req_i(stby),
    .do_o(do_v), .do_oe_o(oe), .ctrl_o(ctrl), .frame_err_o(ferr),
    .gap_err_o(gerr), .active_o(act)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: got %h expected %h", req, cyc, got, exp);
    end
  endtask

  // behavioural reference: pins seen three edges late (R10)
  logic [3:0] h_ck, h_cs, h_di;
  logic [W-1:0] m_tx, m_rx, m_ctrl;
  int m_n, m_gap;
  bit m_oe, m_ok, m_ferr, m_gerr, m_act, m_long;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_ck = '0; h_cs = '1; h_di = '0;
      m_tx = '0; m_rx = '0; m_ctrl = '0; m_n = 0; m_gap = LONG_N;
      m_oe = 0; m_ok = 0; m_ferr = 0; m_gerr = 0; m_act = 0; m_long = 1;
    end else begin
      automatic bit cs_f = h_cs[2] && !h_cs[1];
      automatic bit cs_r = !h_cs[2] && h_cs[1];
      automatic bit ck_r = !h_ck[2] && h_ck[1];
      automatic bit ck_f = h_ck[2] && !h_ck[1];
      automatic int need = m_long ? LONG_N : SHORT_N;
      if (cs_f) begin
        m_oe = 1; m_tx = {fault, status}; m_n = 0;
        m_ok = (m_gap >= need);
        if (!m_ok) m_gerr = 1;
      end else if (cs_r) begin
        m_oe = 0;
        if (m_n == W) begin
          if (m_ok) begin m_ctrl = m_rx; m_long = !m_act; m_act = 1; end
        end else m_ferr = 1;
        m_gap = 1;
      end else if (!h_cs[1]) begin
        if (ck_r) begin m_rx = {m_rx[W-2:0], h_di[1]}; if (m_n < W + 1) m_n++; end
        if (ck_f) m_tx = m_tx << 1;
      end
      if (h_cs[1] && !cs_r && m_gap < LONG_N) m_gap++;
      if (stby) m_act = 0;
      h_ck = {h_ck[2:0], sck}; h_cs = {h_cs[2:0], csn}; h_di = {h_di[2:0], di};
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2 do_o", 32'(do_v), 32'(m_oe & m_tx[W-1]));
      chk("R3 do_oe_o", 32'(oe), 32'(m_oe));
      chk("R5 ctrl_o", 32'(ctrl), 32'(m_ctrl));
      chk("R6 frame_err_o", 32'(ferr), 32'(m_ferr));
      chk("R7 gap_err_o", 32'(gerr), 32'(m_gerr));
      chk("R8 active_o", 32'(act), 32'(m_act));
    end
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: got hung expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // serial clock = system clock / 8; R1 MSB first
  task automatic send(input logic [W-1:0] data, input int nbits);
    csn = 1'b0;
    idle(4);
    chk("R4 fault first", 32'(do_v), 32'(fault));
    chk("R3 enabled", 32'(oe), 32'd1);
    for (int i = 0; i < nbits; i++) begin
      di = (i < W) ? data[W-1-i] : 1'b0;
      sck = 1'b0; idle(4);
      sck = 1'b1; idle(4);
    end
    sck = 1'b0; idle(4);
    csn = 1'b1;
    idle(4);
  endtask

  initial begin
    idle(3);
    chk("R9 ctrl reset", 32'(ctrl), 32'd0);
    chk("R9 oe reset", 32'(oe), 32'd0);
    rst_n = 1'b1;
    idle(2);
    chk("R9 flags reset", {29'd0, ferr, gerr, act}, 32'd0);
    status = 23'h5A3C1; fault = 1'b0;
    send(24'hA53C96, W);
    chk("R1 ctrl A", 32'(ctrl), 32'hA53C96);
    chk("R8 active", 32'(act), 32'd1);
    idle(LONG_N + 100);
    fault = 1'b1; status = 23'h2F0F0;
    send(24'h5A0FF0, W);
    chk("R5 ctrl B", 32'(ctrl), 32'h5A0FF0);
    idle(SHORT_N + 50);
    fault = 1'b0;
    send(24'h123456, W - 1);
    chk("R6 short frame", {31'd0, ferr}, 32'd1);
    chk("R6 ctrl kept", 32'(ctrl), 32'h5A0FF0);
    idle(SHORT_N + 50);
    send(24'h654321, W + 1);
    chk("R6 long frame ctrl kept", 32'(ctrl), 32'h5A0FF0);
    idle(100);
    send(24'h0F0F0F, W);
    chk("R7 gap err", {31'd0, gerr}, 32'd1);
    chk("R7 ctrl kept", 32'(ctrl), 32'h5A0FF0);
    idle(SHORT_N + 50);
    stby = 1'b1; idle(1); stby = 1'b0; idle(2);
    chk("R8 standby", 32'(act), 32'd0);
    send(24'hC3C3C3, W);
    chk("R7 ctrl C", 32'(ctrl), 32'hC3C3C3);
    idle(500);
    send(24'h3C3C3C, W);
    chk("R7 long gap needed", 32'(ctrl), 32'hC3C3C3);
    idle(LONG_N + 100);
    fault = 1'b1;
    send(24'hFFFFFE, W);
    chk("R5 ctrl E", 32'(ctrl), 32'hFFFFFE);
    idle(20);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule